// File: doc/BRIEF.md
# Branch Trace Recorder

This block sits beside a processor pipeline model and watches its taken branches. Each branch arrives as a from-address and to-address pair with the current privilege level. Depending on a 16-bit control word, the block does three things with it. It pushes the pair onto a small ring of recent branches that software reads back. It writes the pair as a two-word record into a trace buffer in memory. It also announces the pair on a one-cycle message output.

Software programs the control word and the trace buffer geometry (base address, size in records, write index) over a simple register bus. Filters can mute the trace path at privilege level 0 or above it, and while the system-management-mode input is high. A performance-monitor interrupt request can freeze the recent-branch ring and raise a counter-freeze output until software releases it. When the buffer fills, it either wraps or stops and raises a level interrupt.

The branch input is valid/ready. The block holds `br_ready` low while a trace record is being written, so a branch stalls rather than being lost. The memory write port is valid/ready as well. While `mem_ready` is low, the address and data presented stay unchanged. The message output and the register bus carry no back-pressure.

Top module: `brtrace_ctl`

Register map (word addresses on `reg_addr`): 0 control, 1 freeze status (bit 0, write 1 to clear), 2 ring top index (read only), 3 buffer base, 4 buffer size in records, 5 buffer write index, 6 buffer status (bit 0 = interrupt, read only), 16+i ring entry i from-address, 24+i ring entry i to-address. Control bits: 0 ring enable, 6 message enable, 7 buffer logging enable, 8 stop-and-interrupt on full, 9 mute trace at level 0, 10 mute trace above level 0, 11 freeze ring on interrupt request, 12 counter freeze on interrupt request, 14 freeze in system-management mode. Bit 1 is storage only.

## Requirements
- R1: After reset the control word, freeze status, ring top index and write index read 0. `buf_irq`, `freeze_out`, `mem_valid` and `msg_valid` are 0, and `br_ready` is 1.
- R2: With control bit 0 set, each accepted branch moves the top index to (top+1) mod 8 and stores the branch's from and to addresses in that entry, which can be read at 16+i and 24+i. With bit 0 clear, the ring is untouched.
- R3: With control bit 7 set, an accepted branch writes the from-address to base+2*index and the to-address to base+2*index+1 in two beats. `br_ready` is low while either beat is pending, and the beat outputs hold steady while `mem_ready` is low.
- R4: With control bit 6 set, `msg_valid` pulses for one cycle after acceptance, carrying that branch's from and to addresses.
- R5: With control bit 8 clear, the write index returns to 0 after the record in slot size-1 completes.
- R6: With control bit 8 set, completing the record in slot size-1 leaves the index at size and raises `buf_irq`. Later branches write nothing until software writes the index, which also clears `buf_irq`.
- R7: Control bit 9 mutes logging and messages when `br_cpl` is 0, and bit 10 mutes them when `br_cpl` is not 0. The ring is not affected by these bits.
- R8: `pmi_req` with control bit 11 or 12 set sets freeze status. While it is set, bit 11 stops ring recording and bit 12 drives `freeze_out` high. Freeze status clears when 1 is written to status bit 0, or when a control write has bit 0 clear.
- R9: While `smm_in` is high and control bit 14 is set, logging and messages are muted and `freeze_out` is high.
- R10: Control bits 2 to 5, 13 and 15 read as 0 whatever is written to them.
- R11: A control write and a branch in the same cycle are handled as if the write came first, so the new value governs that branch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Taken-branch event valid |
| br_ready | output | 1 | Block can accept a branch |
| br_from | input | W | Branch source address |
| br_to | input | W | Branch target address |
| br_cpl | input | 2 | Privilege level of the branch |
| smm_in | input | 1 | System-management mode active |
| pmi_req | input | 1 | Performance-monitor interrupt request |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | TW+2 | Register word address |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Register read data (combinational from reg_addr) |
| mem_valid | output | 1 | Trace buffer beat valid |
| mem_ready | input | 1 | Memory accepts beat |
| mem_addr | output | W | Trace buffer word address |
| mem_data | output | W | Trace buffer word data |
| msg_valid | output | 1 | Branch message pulse |
| msg_from | output | W | Message source address |
| msg_to | output | W | Message target address |
| buf_irq | output | 1 | Buffer-full interrupt (level) |
| freeze_out | output | 1 | Hold global counter enables |

## Verification
A wrong write index or base shows on `mem_addr` at the very next record, one cycle after that record's branch is accepted. A wrap or full decision made in the wrong cycle shows on the record after the boundary. A stuck writer state shows at once as `br_ready` held low, which stalls the branch driver. A bad ring pointer stays hidden until the top index or an entry is read, so the scoreboard reads them back right after each group of branches. Filter and freeze faults appear as an unexpected or missing beat or message in the same or the next cycle.

// File: rtl/brt_pkg.sv
package brt_pkg;
  localparam int unsigned A_CTRL  = 0;
  localparam int unsigned A_FRZ   = 1;
  localparam int unsigned A_TOS   = 2;
  localparam int unsigned A_BASE  = 3;
  localparam int unsigned A_SIZE  = 4;
  localparam int unsigned A_IDX   = 5;
  localparam int unsigned A_BSTAT = 6;

  localparam int B_LBR     = 0;
  localparam int B_MSG     = 6;
  localparam int B_LOG     = 7;
  localparam int B_STOPIRQ = 8;
  localparam int B_MUTE0   = 9;
  localparam int B_MUTEN0  = 10;
  localparam int B_FRZLBR  = 11;
  localparam int B_FRZCNT  = 12;
  localparam int B_SMMFRZ  = 14;

  localparam logic [15:0] CTRL_MASK = 16'h5FC3;

  typedef enum logic [1:0] {TB_IDLE, TB_B0, TB_B1} tb_state_t;
endpackage

// File: rtl/brt_ctrl.sv
module brt_ctrl
  import brt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic        stat_wr,
  input  logic [15:0] wdata16,
  input  logic        pmi_req,
  input  logic        smm_in,
  input  logic [1:0]  cpl,
  output logic [15:0] ctl_q,
  output logic        frz_q,
  output logic        lbr_en,
  output logic        log_en,
  output logic        msg_en,
  output logic        freeze_out
);
  logic [15:0] eff;
  logic        priv_ok, smm_blk, frz_set, frz_clr;
  logic        unused_eff;

  // a write in this cycle governs a branch in this cycle
  assign eff     = ctl_wr ? (wdata16 & CTRL_MASK) : ctl_q;
  assign priv_ok = !(eff[B_MUTE0] && cpl == 2'd0) && !(eff[B_MUTEN0] && cpl != 2'd0);
  assign smm_blk = eff[B_SMMFRZ] && smm_in;
  assign lbr_en  = eff[B_LBR] && !(frz_q && eff[B_FRZLBR]);
  assign log_en  = eff[B_LOG] && priv_ok && !smm_blk;
  assign msg_en  = eff[B_MSG] && priv_ok && !smm_blk;
  assign unused_eff = ^{eff[15:12], eff[8], eff[5:1]};

  assign frz_set = pmi_req && (ctl_q[B_FRZLBR] || ctl_q[B_FRZCNT]);
  assign frz_clr = (stat_wr && wdata16[0]) || (ctl_wr && !wdata16[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      frz_q <= 1'b0;
    end else begin
      if (ctl_wr) ctl_q <= wdata16 & CTRL_MASK;
      if (frz_set)      frz_q <= 1'b1;
      else if (frz_clr) frz_q <= 1'b0;
    end
  end

  assign freeze_out = (frz_q && ctl_q[B_FRZCNT]) || (ctl_q[B_SMMFRZ] && smm_in);

  // R8: freeze status is sticky until software touches a register
  p_freeze_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frz_q && !ctl_wr && !stat_wr |=> frz_q);
endmodule

// File: rtl/brt_lbr.sv
module brt_lbr #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rec,
  input  logic [W-1:0]  rec_from,
  input  logic [W-1:0]  rec_to,
  input  logic [TW-1:0] rd_idx,
  output logic [TW-1:0] tos,
  output logic [W-1:0]  rd_from,
  output logic [W-1:0]  rd_to
);
  logic [W-1:0]  ent_from [DEPTH];
  logic [W-1:0]  ent_to   [DEPTH];
  logic [TW-1:0] wptr;

  assign wptr = (tos == TW'(DEPTH - 1)) ? '0 : tos + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)   tos <= '0;
    else if (rec) tos <= wptr;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_from[i] <= '0;
        ent_to[i]   <= '0;
      end else if (rec && wptr == TW'(i)) begin
        ent_from[i] <= rec_from;
        ent_to[i]   <= rec_to;
      end
    end
  end

  assign rd_from = ent_from[rd_idx];
  assign rd_to   = ent_to[rd_idx];

  // R2: ring wraps from the last entry to entry 0
  p_tos_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rec && tos == TW'(DEPTH - 1) |=> tos == '0);
  // R2: no record, no movement
  p_tos_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rec |=> $stable(tos));
endmodule

// File: rtl/brt_tbuf.sv
module brt_tbuf
  import brt_pkg::*;
#(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          irq_mode,
  input  logic [W-1:0]  rec_from,
  input  logic [W-1:0]  rec_to,
  input  logic          wr_base,
  input  logic          wr_size,
  input  logic          wr_idx,
  input  logic [W-1:0]  wdata,
  input  logic          mem_ready,
  output logic          idle,
  output logic          mem_valid,
  output logic [W-1:0]  mem_addr,
  output logic [W-1:0]  mem_data,
  output logic [W-1:0]  base_q,
  output logic [IW-1:0] size_q,
  output logic [IW-1:0] idx_q,
  output logic          irq_q
);
  tb_state_t   st;
  logic [W-1:0] rec_addr, from_q, to_q;
  logic [IW:0]  nidx;
  logic         full_hit;

  assign nidx     = {1'b0, idx_q} + 1'b1;
  assign full_hit = nidx >= {1'b0, size_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= TB_IDLE;
      rec_addr <= '0;
      from_q   <= '0;
      to_q     <= '0;
      base_q   <= '0;
      size_q   <= '0;
      idx_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      case (st)
        TB_IDLE: if (start) begin
          st       <= TB_B0;
          from_q   <= rec_from;
          to_q     <= rec_to;
          rec_addr <= base_q + W'({idx_q, 1'b0});
        end
        TB_B0: if (mem_ready) st <= TB_B1;
        TB_B1: if (mem_ready) begin
          st <= TB_IDLE;
          if (!full_hit)     idx_q <= nidx[IW-1:0];
          else if (irq_mode) begin
            idx_q <= nidx[IW-1:0];
            irq_q <= 1'b1;
          end else           idx_q <= '0;
        end
        default: st <= TB_IDLE;
      endcase
      if (wr_base) base_q <= wdata;
      if (wr_size) size_q <= wdata[IW-1:0];
      if (wr_idx) begin
        idx_q <= wdata[IW-1:0];
        irq_q <= 1'b0;
      end
    end
  end

  assign idle      = (st == TB_IDLE);
  assign mem_valid = !idle;
  assign mem_addr  = rec_addr + W'(st == TB_B1);
  assign mem_data  = (st == TB_B1) ? to_q : from_q;

  // R3: a stalled beat keeps its address and data
  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));
  // R3: second beat follows at the next word
  p_beat_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st == TB_B0 && mem_ready |=> mem_valid && mem_addr == $past(mem_addr) + 1'b1);
  // R6: nothing starts while the full interrupt stands
  p_drop_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> !start);
endmodule

// File: rtl/brtrace_ctl.sv
module brtrace_ctl
  import brt_pkg::*;
#(
  parameter int  W         = 32,
  parameter int  IW        = 16,
  parameter int  LBR_DEPTH = 8,
  localparam int TW        = $clog2(LBR_DEPTH),
  localparam int RAW       = TW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           br_valid,
  output logic           br_ready,
  input  logic [W-1:0]   br_from,
  input  logic [W-1:0]   br_to,
  input  logic [1:0]     br_cpl,
  input  logic           smm_in,
  input  logic           pmi_req,
  input  logic           reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [W-1:0]   reg_wdata,
  output logic [W-1:0]   reg_rdata,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic [W-1:0]   mem_addr,
  output logic [W-1:0]   mem_data,
  output logic           msg_valid,
  output logic [W-1:0]   msg_from,
  output logic [W-1:0]   msg_to,
  output logic           buf_irq,
  output logic           freeze_out
);
  logic [15:0]   ctl_q;
  logic          frz_q, lbr_en, log_en, msg_en, acc, tb_idle;
  logic          ctl_wr, stat_wr, base_wr, size_wr, idx_wr;
  logic [TW-1:0] tos;
  logic [W-1:0]  lbr_from, lbr_to, base_q;
  logic [IW-1:0] size_q, idx_q;

  assign ctl_wr  = reg_wr && reg_addr == RAW'(A_CTRL);
  assign stat_wr = reg_wr && reg_addr == RAW'(A_FRZ);
  assign base_wr = reg_wr && reg_addr == RAW'(A_BASE);
  assign size_wr = reg_wr && reg_addr == RAW'(A_SIZE);
  assign idx_wr  = reg_wr && reg_addr == RAW'(A_IDX);

  assign br_ready = tb_idle;
  assign acc      = br_valid && br_ready;

  brt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .stat_wr(stat_wr),
    .wdata16(reg_wdata[15:0]), .pmi_req(pmi_req), .smm_in(smm_in), .cpl(br_cpl),
    .ctl_q(ctl_q), .frz_q(frz_q), .lbr_en(lbr_en), .log_en(log_en),
    .msg_en(msg_en), .freeze_out(freeze_out)
  );

  brt_lbr #(.W(W), .DEPTH(LBR_DEPTH)) u_lbr (
    .clk(clk), .rst_n(rst_n), .rec(acc && lbr_en), .rec_from(br_from), .rec_to(br_to),
    .rd_idx(reg_addr[TW-1:0]), .tos(tos), .rd_from(lbr_from), .rd_to(lbr_to)
  );

  brt_tbuf #(.W(W), .IW(IW)) u_tbuf (
    .clk(clk), .rst_n(rst_n), .start(acc && log_en && !buf_irq),
    .irq_mode(ctl_q[B_STOPIRQ]), .rec_from(br_from), .rec_to(br_to),
    .wr_base(base_wr), .wr_size(size_wr), .wr_idx(idx_wr), .wdata(reg_wdata),
    .mem_ready(mem_ready), .idle(tb_idle), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_data(mem_data), .base_q(base_q),
    .size_q(size_q), .idx_q(idx_q), .irq_q(buf_irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_from  <= '0;
      msg_to    <= '0;
    end else begin
      msg_valid <= acc && msg_en;
      if (acc) begin
        msg_from <= br_from;
        msg_to   <= br_to;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[RAW-1]) begin
      reg_rdata = reg_addr[TW] ? lbr_to : lbr_from;
    end else begin
      case (reg_addr)
        RAW'(A_CTRL):  reg_rdata = W'(ctl_q);
        RAW'(A_FRZ):   reg_rdata = W'(frz_q);
        RAW'(A_TOS):   reg_rdata = W'(tos);
        RAW'(A_BASE):  reg_rdata = base_q;
        RAW'(A_SIZE):  reg_rdata = W'(size_q);
        RAW'(A_IDX):   reg_rdata = W'(idx_q);
        RAW'(A_BSTAT): reg_rdata = W'(buf_irq);
        default:       reg_rdata = '0;
      endcase
    end
  end

  // R3: no branch accepted while a record is in flight
  p_busy_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !br_ready);
  // R8: frozen ring does not move without a register write
  p_frozen_lbr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frz_q && ctl_q[B_FRZLBR] && !reg_wr |=> $stable(tos));
  // R9: no message leaves for a branch taken in system-management mode
  p_smm_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && smm_in && ctl_q[B_SMMFRZ] && !reg_wr |=> !msg_valid);
  // R10: reserved control bits never become set
  p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q & ~CTRL_MASK) == 16'h0);
endmodule

// File: tb/brtrace_ctl_tb_top.sv
module brtrace_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_valid = 1'b0, smm_in = 1'b0, pmi_req = 1'b0, reg_wr = 1'b0;
  logic        mem_ready = 1'b1;
  logic [31:0] br_from = '0, br_to = '0, reg_wdata = '0;
  logic [1:0]  br_cpl = '0;
  logic [4:0]  reg_addr = '0;
  logic        br_ready, mem_valid, msg_valid, buf_irq, freeze_out;
  logic [31:0] reg_rdata, mem_addr, mem_data, msg_from, msg_to;

  int total = 0, bad = 0, cyc = 0;
  bit stall_en = 1'b0, done = 1'b0;
  logic [63:0] mq[$];
  logic [63:0] sq[$];
  logic [31:0] d, t0;

  always #2.5 clk = ~clk;

  brtrace_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_ready(br_ready),
    .br_from(br_from), .br_to(br_to), .br_cpl(br_cpl), .smm_in(smm_in),
    .pmi_req(pmi_req), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .msg_valid(msg_valid),
    .msg_from(msg_from), .msg_to(msg_to), .buf_irq(buf_irq), .freeze_out(freeze_out)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] v);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  // driver: pushes expected beats/messages, then offers the branch
  task automatic send(input logic [31:0] f, input logic [31:0] tt, input logic [1:0] c,
                      input bit logd, input logic [31:0] addr, input bit msgd);
    if (logd) begin
      mq.push_back({addr, f});
      mq.push_back({addr + 32'd1, tt});
    end
    if (msgd) sq.push_back({f, tt});
    @(posedge clk); #1;
    br_valid = 1'b1; br_from = f; br_to = tt; br_cpl = c;
    do @(negedge clk); while (!br_ready);
    @(posedge clk); #1;
    br_valid = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (!br_ready) @(negedge clk);
  endtask

  task automatic pmi_pulse();
    @(posedge clk); #1; pmi_req = 1'b1;
    @(posedge clk); #1; pmi_req = 1'b0;
  endtask

  always @(posedge clk) begin
    #1;
    cyc++;
    mem_ready = stall_en ? (cyc % 3 != 2) : 1'b1;
  end

  // monitor: compares produced items against the scoreboard queues
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (mem_valid) begin
        total++;
        if (br_ready) begin bad++; $display("FAIL R3 br_ready high during beat got=1 exp=0"); end
      end
      if (mem_valid && mem_ready) begin
        total++;
        if (mq.size() == 0) begin
          bad++;
          $display("FAIL R3/R6 unexpected beat got=%h:%h exp=none", mem_addr, mem_data);
        end else begin
          logic [63:0] e;
          e = mq.pop_front();
          if ({mem_addr, mem_data} !== e) begin
            bad++;
            $display("FAIL R3/R5 beat got=%h:%h exp=%h:%h", mem_addr, mem_data, e[63:32], e[31:0]);
          end
        end
      end
      if (msg_valid) begin
        total++;
        if (sq.size() == 0) begin
          bad++;
          $display("FAIL R4/R7 unexpected message got=%h:%h exp=none", msg_from, msg_to);
        end else begin
          logic [63:0] e;
          e = sq.pop_front();
          if ({msg_from, msg_to} !== e) begin
            bad++;
            $display("FAIL R4 message got=%h:%h exp=%h:%h", msg_from, msg_to, e[63:32], e[31:0]);
          end
        end
      end
    end
  end

  initial begin
    #750000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1 br_ready", br_ready, 1);
    chk("R1 mem_valid", mem_valid, 0);
    chk("R1 buf_irq", buf_irq, 0);
    chk("R1 freeze_out", freeze_out, 0);
    chk("R1 msg_valid", msg_valid, 0);
    rd(5'd0, d); chk("R1 ctrl", d, 0);
    rd(5'd1, d); chk("R1 freeze status", d, 0);
    rd(5'd2, d); chk("R1 tos", d, 0);
    rd(5'd5, d); chk("R1 index", d, 0);

    // R10 reserved bits
    wr(5'd0, 32'hFFFF);
    rd(5'd0, d); chk("R10 ctrl readback", d, 32'h5FC3);
    wr(5'd0, 32'h0);

    // R2 ring disabled then enabled
    send(32'h50, 32'h60, 2'd1, 0, 0, 0);
    rd(5'd2, d); chk("R2 tos unchanged when off", d, 0);
    wr(5'd0, 32'h1);
    for (int k = 0; k < 10; k++) send(32'h100 + k, 32'h200 + k, 2'd1, 0, 0, 0);
    rd(5'd2, d); chk("R2 tos after 10", d, 2);
    rd(5'd18, d); chk("R2 newest from", d, 32'h109);
    rd(5'd26, d); chk("R2 newest to", d, 32'h209);
    rd(5'd17, d); chk("R2 entry1 from", d, 32'h108);
    rd(5'd19, d); chk("R2 entry3 from", d, 32'h102);

    // R3 + R5 circular logging with back-pressure
    wr(5'd3, 32'h1000);
    wr(5'd4, 32'd3);
    wr(5'd5, 32'd0);
    wr(5'd0, 32'h81);
    stall_en = 1'b1;
    send(32'hA0, 32'hB0, 2'd0, 1, 32'h1000, 0);
    send(32'hA1, 32'hB1, 2'd0, 1, 32'h1002, 0);
    send(32'hA2, 32'hB2, 2'd0, 1, 32'h1004, 0);
    send(32'hA3, 32'hB3, 2'd0, 1, 32'h1000, 0);
    wait_idle();
    stall_en = 1'b0;
    rd(5'd5, d); chk("R5 index after wrap", d, 1);
    chk("R5 no irq in circular mode", buf_irq, 0);

    // R6 stop on full with interrupt
    wr(5'd3, 32'h2000);
    wr(5'd4, 32'd2);
    wr(5'd5, 32'd0);
    wr(5'd0, 32'h181);
    send(32'hC0, 32'hD0, 2'd0, 1, 32'h2000, 0);
    send(32'hC1, 32'hD1, 2'd0, 1, 32'h2002, 0);
    wait_idle();
    @(negedge clk);
    chk("R6 irq raised", buf_irq, 1);
    send(32'hC2, 32'hD2, 2'd0, 0, 0, 0);
    wait_idle();
    rd(5'd5, d); chk("R6 index at size", d, 2);
    rd(5'd6, d); chk("R6 status bit", d, 1);
    wr(5'd5, 32'd0);
    @(negedge clk);
    chk("R6 irq cleared by index write", buf_irq, 0);
    send(32'hC3, 32'hD3, 2'd0, 1, 32'h2000, 0);
    wait_idle();

    // R4 + R7 privilege filtering
    wr(5'd3, 32'h3000);
    wr(5'd4, 32'd4);
    wr(5'd5, 32'd0);
    wr(5'd0, 32'h02C1);
    rd(5'd2, t0);
    send(32'hE0, 32'hF0, 2'd0, 0, 0, 0);
    send(32'hE1, 32'hF1, 2'd3, 1, 32'h3000, 1);
    wait_idle();
    wr(5'd0, 32'h04C1);
    send(32'hE2, 32'hF2, 2'd2, 0, 0, 0);
    send(32'hE3, 32'hF3, 2'd0, 1, 32'h3002, 1);
    wait_idle();
    rd(5'd2, d); chk("R7 ring not filtered", d, (t0 + 4) % 8);

    // R8 freeze on interrupt request
    wr(5'd0, 32'h1801);
    pmi_pulse();
    @(negedge clk);
    chk("R8 freeze_out", freeze_out, 1);
    rd(5'd1, d); chk("R8 status set", d, 1);
    rd(5'd2, t0);
    send(32'h11, 32'h22, 2'd0, 0, 0, 0);
    rd(5'd2, d); chk("R8 ring frozen", d, t0);
    wr(5'd1, 32'h1);
    rd(5'd1, d); chk("R8 status cleared W1C", d, 0);
    chk("R8 freeze_out released", freeze_out, 0);
    send(32'h12, 32'h23, 2'd0, 0, 0, 0);
    rd(5'd2, d); chk("R8 ring resumes", d, (t0 + 1) % 8);
    pmi_pulse();
    rd(5'd1, d); chk("R8 status set again", d, 1);
    wr(5'd0, 32'h1800);
    rd(5'd1, d); chk("R8 cleared by ctrl bit0 low", d, 0);

    // R9 system-management freeze
    wr(5'd5, 32'd0);
    wr(5'd0, 32'h40C0);
    @(posedge clk); #1 smm_in = 1'b1;
    @(negedge clk);
    chk("R9 freeze_out in smm", freeze_out, 1);
    send(32'h31, 32'h41, 2'd0, 0, 0, 0);
    @(posedge clk); #1 smm_in = 1'b0;
    @(negedge clk);
    chk("R9 freeze_out after smm", freeze_out, 0);
    send(32'h32, 32'h42, 2'd0, 1, 32'h3000, 1);
    wait_idle();

    // R11 same-cycle write and branch
    wr(5'd0, 32'h0);
    rd(5'd2, t0);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = 5'd0; reg_wdata = 32'h1;
    br_valid = 1'b1; br_from = 32'h77; br_to = 32'h88; br_cpl = 2'd0;
    @(posedge clk); #1;
    reg_wr = 1'b0; br_valid = 1'b0;
    rd(5'd2, d); chk("R11 enable applies to same branch", d, (t0 + 1) % 8);
    rd(5'(16 + d), d); chk("R11 entry from", d, 32'h77);
    rd(5'd2, t0);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = 5'd0; reg_wdata = 32'h0;
    br_valid = 1'b1; br_from = 32'h78; br_to = 32'h89;
    @(posedge clk); #1;
    reg_wr = 1'b0; br_valid = 1'b0;
    rd(5'd2, d); chk("R11 disable applies to same branch", d, t0);

    repeat (10) @(negedge clk);
    chk("R3 all beats seen", mq.size(), 0);
    chk("R4 all messages seen", sq.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule